// File: doc/BRIEF.md
# Interlaced Field Beam Sequencer

This block keeps the vertical beam position of a video output path. Each line tick moves a beam line counter on by one. From the counter value held before the step, the block decides whether a field starts or finishes. It then emits single-cycle begin and end strobes together with a code for the field type. The video format selects the total line count and the two field start lines:

- Format 0 is the 525-line timing.
- Formats 1 and 2 both use the 625-line timing. They differ only in field rate, which does not affect this block.
- Format 3 is a debug mode that freezes the sequencer.

The non-interlace input picks progressive operation. In that mode the wrap point is twice the line count and a progressive field starts at line 1. In interlaced mode an upper field starts at the upper start line and a lower field at the lower start line. The counter wraps to 1 at the limit. It reads 0 only out of reset, which means the beam is inactive.

A per-line compare strobe comes out in the same cycle that the stepped beam line becomes visible. A neighbouring line-interrupt bank can therefore compare its trigger lines against the new value.

Top module: `field_beam_seq`

## Requirements
- R1: While reset is asserted and directly after it, beam_line is 0, field_begin, field_end and line_cmp_stb are 0, and field_kind is 0.
- R2: In formats 0, 1 and 2, a cycle with line_tick high steps beam_line by one at that clock edge, and line_cmp_stb is high for exactly the following cycle. A cycle without line_tick leaves beam_line unchanged and line_cmp_stb low.
- R3: When the stepped value would exceed the wrap limit, beam_line becomes 1, never 0. This also holds when a format change leaves beam_line above the new limit.
- R4: The wrap limit is the format's line count times the field count. Format 0 has 525 lines and formats 1 and 2 have 625 lines. The field count is 2 with prog_mode high and 1 otherwise.
- R5: With prog_mode high, a tick taken while beam_line is 1 raises field_begin in the next cycle with field_kind 0 (progressive).
- R6: With prog_mode low, a tick taken at the upper start line (format 0: 21, formats 1 and 2: 23) raises field_begin with field_kind 1. A tick at the lower start line (format 0: 284, formats 1 and 2: 336) raises field_begin with field_kind 2.
- R7: A tick taken while beam_line equals an upper or lower start line plus active_lines raises field_end. In either mode, field_kind is then 1 for an upper-end match and 2 otherwise, unless a begin fires in the same cycle, in which case the begin's kind wins.
- R8: In format 3 a tick is ignored: beam_line holds, and no strobe and no compare pulse is issued.
- R9: field_begin and field_end are single-cycle pulses that occur only in the cycle after a taken tick. field_kind changes only when one of them fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_tick | input | 1 | One-cycle pulse per video line |
| prog_mode | input | 1 | 1 = non-interlaced (progressive) operation |
| vid_fmt | input | 2 | 0: 525-line, 1: 625-line, 2: 625-line at 60 Hz rate, 3: debug hold |
| active_lines | input | LINE_W | Active lines per field |
| beam_line | output | LINE_W | Current vertical beam line, 0 = inactive |
| field_begin | output | 1 | Field start pulse |
| field_end | output | 1 | Field end pulse |
| field_kind | output | 2 | 0 progressive, 1 upper, 2 lower |
| line_cmp_stb | output | 1 | Pulse marking a new beam_line value for interrupt matching |

## Verification
The bench runs full frames in every format and both modes, so that each wrap is crossed. A design that wraps to 0, or that uses the single-field limit in progressive mode, loses step with the model at lines 525, 1050 or 1250.

Random format switches drop the beam above a smaller limit. A design that tests for equality with the limit instead of exceeding it would then count up to the register maximum.

Debug-format ticks check that the counter freezes. The begin and end lines are checked for the value used: a design that decodes them from the stepped value instead of the held one fires one line early.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic [1:0] {
      FK_PROG  = 2'd0,
      FK_UPPER = 2'd1,
      FK_LOWER = 2'd2
   } field_kind_e;

   typedef enum logic [1:0] {
      VF_525    = 2'd0,
      VF_625    = 2'd1,
      VF_625_60 = 2'd2,
      VF_DEBUG  = 2'd3
   } vid_fmt_e;

   localparam int NUM_FMT = 4;

endpackage

// File: rtl/fbs_fmt_sel.sv
module fbs_fmt_sel
   import fbs_pkg::*;
#(
   parameter int LINE_W     = 11,
   parameter int NTSC_LINES = 525,
   parameter int NTSC_UPPER = 21,
   parameter int NTSC_LOWER = 284,
   parameter int PAL_LINES  = 625,
   parameter int PAL_UPPER  = 23,
   parameter int PAL_LOWER  = 336
) (
   input  logic [1:0]        vid_fmt,
   input  logic              prog_mode,
   output logic [LINE_W-1:0] wrap_limit,
   output logic [LINE_W-1:0] upper_start,
   output logic [LINE_W-1:0] lower_start,
   output logic              fmt_halt
);

   logic [LINE_W-1:0] lines_tab [NUM_FMT];
   logic [LINE_W-1:0] upper_tab [NUM_FMT];
   logic [LINE_W-1:0] lower_tab [NUM_FMT];
   logic              halt_tab  [NUM_FMT];

   // one table row per format code
   for (genvar g = 0; g < NUM_FMT; g++) begin : g_row
      if (g == int'(VF_525)) begin : g_525
         assign lines_tab[g] = LINE_W'(NTSC_LINES);
         assign upper_tab[g] = LINE_W'(NTSC_UPPER);
         assign lower_tab[g] = LINE_W'(NTSC_LOWER);
         assign halt_tab[g]  = 1'b0;
      end else if (g == int'(VF_DEBUG)) begin : g_dbg
         assign lines_tab[g] = '0;
         assign upper_tab[g] = '0;
         assign lower_tab[g] = '0;
         assign halt_tab[g]  = 1'b1;
      end else begin : g_625
         assign lines_tab[g] = LINE_W'(PAL_LINES);
         assign upper_tab[g] = LINE_W'(PAL_UPPER);
         assign lower_tab[g] = LINE_W'(PAL_LOWER);
         assign halt_tab[g]  = 1'b0;
      end
   end

   logic [LINE_W-1:0] lines_sel;

   always_comb begin
      lines_sel   = lines_tab[vid_fmt];
      upper_start = upper_tab[vid_fmt];
      lower_start = lower_tab[vid_fmt];
      fmt_halt    = halt_tab[vid_fmt];
      // two fields per frame in progressive mode doubles the wrap point
      wrap_limit  = prog_mode ? (lines_sel << 1) : lines_sel;
   end

endmodule

// File: rtl/fbs_boundary.sv
module fbs_boundary
   import fbs_pkg::*;
#(
   parameter int LINE_W = 11
) (
   input  logic [LINE_W-1:0] beam,
   input  logic              prog_mode,
   input  logic [LINE_W-1:0] upper_start,
   input  logic [LINE_W-1:0] lower_start,
   input  logic [LINE_W-1:0] active_lines,
   output logic              begin_hit,
   output logic              end_hit,
   output field_kind_e       hit_kind
);

   localparam int SUM_W = LINE_W + 1;

   logic [SUM_W-1:0] beam_x;
   logic [SUM_W-1:0] upper_end;
   logic [SUM_W-1:0] lower_end;
   logic             up_hit, lo_hit, first_hit;
   logic             up_end_hit, lo_end_hit;

   always_comb begin
      beam_x     = {1'b0, beam};
      upper_end  = {1'b0, upper_start} + {1'b0, active_lines};
      lower_end  = {1'b0, lower_start} + {1'b0, active_lines};
      up_hit     = (beam == upper_start);
      lo_hit     = (beam == lower_start);
      first_hit  = (beam == LINE_W'(1));
      up_end_hit = (beam_x == upper_end);
      lo_end_hit = (beam_x == lower_end);

      begin_hit  = prog_mode ? first_hit : (up_hit | lo_hit);
      end_hit    = up_end_hit | lo_end_hit;

      if (begin_hit) begin
         if (prog_mode)   hit_kind = FK_PROG;
         else if (up_hit) hit_kind = FK_UPPER;
         else             hit_kind = FK_LOWER;
      end else if (up_end_hit) begin
         hit_kind = FK_UPPER;
      end else begin
         hit_kind = FK_LOWER;
      end
   end

endmodule

// File: rtl/fbs_line_ctr.sv
module fbs_line_ctr #(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [LINE_W-1:0] wrap_limit,
   output logic [LINE_W-1:0] beam
);

   logic [LINE_W:0] beam_inc;
   logic            past_limit;

   always_comb begin
      beam_inc   = {1'b0, beam} + {{LINE_W{1'b0}}, 1'b1};
      // strict greater-than: any position beyond the limit folds back
      past_limit = (beam_inc > {1'b0, wrap_limit});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beam <= '0;
      end else if (advance) begin
         beam <= past_limit ? LINE_W'(1) : beam_inc[LINE_W-1:0];
      end
   end

endmodule

// File: rtl/field_beam_seq.sv
module field_beam_seq
   import fbs_pkg::*;
#(
   parameter int LINE_W     = 11,
   parameter int NTSC_LINES = 525,
   parameter int NTSC_UPPER = 21,
   parameter int NTSC_LOWER = 284,
   parameter int PAL_LINES  = 625,
   parameter int PAL_UPPER  = 23,
   parameter int PAL_LOWER  = 336
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              prog_mode,
   input  logic [1:0]        vid_fmt,
   input  logic [LINE_W-1:0] active_lines,
   output logic [LINE_W-1:0] beam_line,
   output logic              field_begin,
   output logic              field_end,
   output logic [1:0]        field_kind,
   output logic              line_cmp_stb
);

   localparam int MAX_LINES = (NTSC_LINES > PAL_LINES) ? NTSC_LINES : PAL_LINES;
   localparam int MAX_LIMIT = 2 * MAX_LINES;

   // elaboration checks on the parameter set
   if (MAX_LIMIT >= (1 << LINE_W)) begin : g_bad_width
      $error("LINE_W too narrow for doubled line count");
   end
   if (NTSC_UPPER >= NTSC_LINES || NTSC_LOWER >= NTSC_LINES || NTSC_UPPER == NTSC_LOWER) begin : g_bad_525
      $error("525-line start lines out of range");
   end
   if (PAL_UPPER >= PAL_LINES || PAL_LOWER >= PAL_LINES || PAL_UPPER == PAL_LOWER) begin : g_bad_625
      $error("625-line start lines out of range");
   end

   logic [LINE_W-1:0] wrap_limit, upper_start, lower_start;
   logic              fmt_halt;
   logic              begin_hit, end_hit;
   field_kind_e       hit_kind;
   logic              take_tick;

   fbs_fmt_sel #(
      .LINE_W     (LINE_W),
      .NTSC_LINES (NTSC_LINES),
      .NTSC_UPPER (NTSC_UPPER),
      .NTSC_LOWER (NTSC_LOWER),
      .PAL_LINES  (PAL_LINES),
      .PAL_UPPER  (PAL_UPPER),
      .PAL_LOWER  (PAL_LOWER)
   ) u_fmt (
      .vid_fmt     (vid_fmt),
      .prog_mode   (prog_mode),
      .wrap_limit  (wrap_limit),
      .upper_start (upper_start),
      .lower_start (lower_start),
      .fmt_halt    (fmt_halt)
   );

   fbs_boundary #(
      .LINE_W (LINE_W)
   ) u_bnd (
      .beam         (beam_line),
      .prog_mode    (prog_mode),
      .upper_start  (upper_start),
      .lower_start  (lower_start),
      .active_lines (active_lines),
      .begin_hit    (begin_hit),
      .end_hit      (end_hit),
      .hit_kind     (hit_kind)
   );

   assign take_tick = line_tick & ~fmt_halt;

   fbs_line_ctr #(
      .LINE_W (LINE_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (take_tick),
      .wrap_limit (wrap_limit),
      .beam       (beam_line)
   );

   field_kind_e kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_begin  <= 1'b0;
         field_end    <= 1'b0;
         line_cmp_stb <= 1'b0;
         kind_q       <= FK_PROG;
      end else begin
         field_begin  <= take_tick & begin_hit;
         field_end    <= take_tick & end_hit;
         line_cmp_stb <= take_tick;
         if (take_tick && (begin_hit || end_hit)) begin
            kind_q <= hit_kind;
         end
      end
   end

   assign field_kind = kind_q;

endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
   parameter int LINE_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_tick,
   input logic              prog_mode,
   input logic [1:0]        vid_fmt,
   input logic [LINE_W-1:0] active_lines,
   input logic [LINE_W-1:0] beam_line,
   input logic              field_begin,
   input logic              field_end,
   input logic [1:0]        field_kind,
   input logic              line_cmp_stb
);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick |=> ($stable(beam_line) && !line_cmp_stb));

   // R2
   tick_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && vid_fmt != 2'd3) |=> line_cmp_stb);

   // R3
   no_zero_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_cmp_stb |-> (beam_line != '0));

   // R5
   prog_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && prog_mode && vid_fmt != 2'd3 && beam_line == LINE_W'(1))
      |=> (field_begin && field_kind == 2'd0));

   // R8
   debug_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && vid_fmt == 2'd3)
      |=> ($stable(beam_line) && !field_begin && !field_end && !line_cmp_stb));

   // R9
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (field_begin || field_end) |-> $past(line_tick));

   // R9
   kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_kind != 2'd3);

   // R9
   kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!field_begin && !field_end) |-> $stable(field_kind));

   logic unused_ok;
   assign unused_ok = ^active_lines;

endmodule

bind field_beam_seq fbs_chk #(.LINE_W(LINE_W)) u_fbs_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .line_tick    (line_tick),
   .prog_mode    (prog_mode),
   .vid_fmt      (vid_fmt),
   .active_lines (active_lines),
   .beam_line    (beam_line),
   .field_begin  (field_begin),
   .field_end    (field_end),
   .field_kind   (field_kind),
   .line_cmp_stb (line_cmp_stb)
);

// File: tb/tb_field_beam_seq.sv
`timescale 1ns/1ps
module tb_field_beam_seq;

   localparam int LW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_tick = 1'b0;
   logic          prog_mode = 1'b0;
   logic [1:0]    vid_fmt = 2'd0;
   logic [LW-1:0] active_lines = LW'(240);
   logic [LW-1:0] beam_line;
   logic          field_begin, field_end, line_cmp_stb;
   logic [1:0]    field_kind;

   int errors = 0;
   int checks = 0;
   int model_pos = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   field_beam_seq dut (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .prog_mode(prog_mode),
      .vid_fmt(vid_fmt), .active_lines(active_lines), .beam_line(beam_line),
      .field_begin(field_begin), .field_end(field_end), .field_kind(field_kind),
      .line_cmp_stb(line_cmp_stb)
   );

   function automatic int lines_of(int f);
      return (f == 0) ? 525 : 625;
   endfunction
   function automatic int upper_of(int f);
      return (f == 0) ? 21 : 23;
   endfunction
   function automatic int lower_of(int f);
      return (f == 0) ? 284 : 336;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one cycle: drive, clock, compare against the bench model
   task automatic step(bit tick);
      int f, p, acv, lim, nxt, ek;
      bit eb, ee, take;
      @(negedge clk);
      line_tick = tick;
      f = int'(vid_fmt); p = int'(prog_mode); acv = int'(active_lines);
      take = tick && (f != 3);
      eb = 0; ee = 0; ek = 0; nxt = model_pos;
      if (take) begin
         lim = lines_of(f) * (p ? 2 : 1);
         if (p) eb = (model_pos == 1);
         else   eb = (model_pos == upper_of(f)) || (model_pos == lower_of(f));
         ee = (model_pos == upper_of(f) + acv) || (model_pos == lower_of(f) + acv);
         if (eb) ek = p ? 0 : ((model_pos == upper_of(f)) ? 1 : 2);
         else    ek = (model_pos == upper_of(f) + acv) ? 1 : 2;
         nxt = (model_pos + 1 > lim) ? 1 : model_pos + 1;
      end
      @(posedge clk);
      #1;
      line_tick = 1'b0;
      if (f == 3) begin
         check(int'(beam_line) == nxt, "R8 beam hold", int'(beam_line), nxt);
         check(!field_begin && !field_end && !line_cmp_stb, "R8 no strobes",
               int'({field_begin, field_end, line_cmp_stb}), 0);
      end else begin
         if (model_pos + 1 > lines_of(f) * (p ? 2 : 1) && take)
            check(int'(beam_line) == nxt, "R3 wrap to 1", int'(beam_line), nxt);
         else
            check(int'(beam_line) == nxt, "R2 R4 beam step", int'(beam_line), nxt);
         check(line_cmp_stb == take, "R2 cmp strobe", int'(line_cmp_stb), int'(take));
         check(field_begin == eb, p ? "R5 prog begin" : "R6 field begin",
               int'(field_begin), int'(eb));
         check(field_end == ee, "R7 field end", int'(field_end), int'(ee));
         if (eb || ee)
            check(int'(field_kind) == ek, "R7 R9 field kind", int'(field_kind), ek);
      end
      model_pos = nxt;
   endtask

   task automatic run_ticks(int n);
      for (int i = 0; i < n; i++) step(1'b1);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 200000; c++) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed_val;
      seed_val = $urandom(32'd7321);
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(beam_line == '0, "R1 reset beam", int'(beam_line), 0);
      check(!field_begin && !field_end && !line_cmp_stb && field_kind == 2'd0,
            "R1 reset outputs", int'({field_begin, field_end, line_cmp_stb, field_kind}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(beam_line == '0, "R1 after release", int'(beam_line), 0);

      // R2: idle cycles hold
      repeat (3) step(1'b0);

      // directed: interlaced 525-line, two frames
      vid_fmt = 2'd0; prog_mode = 1'b0; active_lines = LW'(240);
      run_ticks(1100);
      // progressive 525-line, wrap at 1050
      prog_mode = 1'b1; active_lines = LW'(480);
      run_ticks(1100);
      // 625-line interlaced and progressive at 60 Hz rate
      vid_fmt = 2'd1; prog_mode = 1'b0; active_lines = LW'(287);
      run_ticks(1300);
      vid_fmt = 2'd2; prog_mode = 1'b1; active_lines = LW'(574);
      run_ticks(1300);
      // R3: drop from high position into a smaller limit
      vid_fmt = 2'd0; prog_mode = 1'b0;
      run_ticks(5);
      // R8: debug format freezes
      vid_fmt = 2'd3;
      run_ticks(6);
      step(1'b0);

      // random mix
      for (int seg = 0; seg < 24; seg++) begin
         int fr;
         fr = int'($urandom_range(0, 9));
         vid_fmt      = (fr == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         prog_mode    = 1'($urandom_range(0, 1));
         active_lines = LW'($urandom_range(1, 320));
         for (int k = 0; k < 260; k++) begin
            step(1'($urandom_range(0, 3) != 0));
         end
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule